// File: doc/BRIEF.md
# SPI Slave Register Read Port

This block lets an external host read a bank of byte-wide registers over a four-wire serial link. The host raises the select line to open a transaction. While select stays high, the host sends command bytes on its data-out line. The slave sends bytes back on its own data line at the same time. Each transaction opens with a two-byte status word. After that, each returned byte answers the command sent two byte slots earlier. A host that wants the last answers keeps clocking. To do so it sends padding commands at address 3Fh, which have no effect.

All serial inputs are synchronised into a system clock that runs at least eight times faster than the serial clock. Both edges of the serial clock are found in that domain. The register bank sits outside the block. The block presents a registered read address and takes the addressed byte back on a parallel input in the following system clock cycle. The status word also comes from outside. It is captured at the first rising serial-clock edge of each transaction.

Top module: `sreg_reader`

## Requirements
- R1: While select is low, `spi_sdo_oe` is 0 and `spi_sdo` is 0.
- R2: The first two bytes on `spi_sdo` of every transaction are the status word: bits 15:8 first, then bits 7:0. Each byte is sent MSB first. The word is sampled at the first rising serial-clock edge.
- R3: The serial clock idles low. `spi_sdo` takes a new bit after each rising edge and is stable at the next falling edge. `spi_sdi` is sampled on the falling edge.
- R4: In a command byte, bit 7 is the read flag (1 = read) and bits 6:0 are the register address. `reg_addr` changes only after a command byte has been fully received.
- R5: The response to the command in byte slot k of a transaction is sent in byte slot k+2. For a valid read, the response is the addressed register's content.
- R6: A read of address 3Fh leaves `reg_addr` unchanged, and its response byte is 00h.
- R7: A command byte with bit 7 at 0 leaves `reg_addr` unchanged, and its response byte is 00h.
- R8: When select drops in the middle of a byte, the partial byte is discarded. The next transaction starts again with the status word.
- R9: After reset, `reg_addr` is 00h and the serial output is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs | input | 1 | Transaction select, active high |
| spi_sck | input | 1 | Serial clock from the host, idles low |
| spi_sdi | input | 1 | Command bits from the host |
| spi_sdo | output | 1 | Status and response bits to the host |
| spi_sdo_oe | output | 1 | Output enable for `spi_sdo` |
| status | input | 16 | Status word sent at the start of each transaction |
| reg_addr | output | 7 | Registered read address to the register bank |
| reg_data | input | 8 | Register content for `reg_addr`, valid one cycle after it changes |

## Verification
The assertions rely on the serial clock having at least four system cycles in each phase. Under that condition, two completed bytes can never fall in adjacent system cycles. A shift is also always followed by a cycle in which the shifter is still active or has been released. The bench drives the serial clock with eight system cycles per phase. It changes select and data only on falling system-clock edges, away from any serial-clock edge. It also keeps `spi_sdi` stable for a full half period around every falling edge. The register content is a fixed function of `reg_addr`, so it is always valid one cycle after the address changes.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
   // serial clock edge flags seen in the system clock domain
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_edge_t;

   function automatic int idx_width(input int n);
      return (n < 2) ? 1 : $clog2(n + 1);
   endfunction
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("sreg_sync: STAGES must be at least 2");
   end

   for (genvar g = 0; g < STAGES; g++) begin : stg
      logic [W-1:0] r;
      if (g == 0) begin : head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= d;
      end else begin : tail
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) r <= '0;
            else        r <= stg[g-1].r;
      end
   end

   assign q = stg[STAGES-1].r;
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
   import sreg_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int STAT_BYTES = 2,
   localparam int BIT_W     = $clog2(DATA_W),
   localparam int IDX_W     = idx_width(STAT_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              sck,
   input  logic              sdi,
   output logic              load,
   output logic              shift,
   output logic              done,
   output logic [DATA_W-1:0] rx_byte,
   output logic [IDX_W-1:0]  tx_idx
);
   logic              sck_q;
   logic [BIT_W-1:0]  bit_cnt;
   logic [DATA_W-1:0] rx_sh;
   sck_edge_t         edg;

   assign edg.rise = sel &  sck & ~sck_q;
   assign edg.fall = sel & ~sck &  sck_q;
   assign load     = edg.rise && (bit_cnt == '0);
   assign shift    = edg.rise && (bit_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q   <= 1'b0;
         bit_cnt <= '0;
         rx_sh   <= '0;
         rx_byte <= '0;
         done    <= 1'b0;
         tx_idx  <= '0;
      end else begin
         sck_q <= sck;
         done  <= 1'b0;
         if (!sel) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_idx  <= '0;
         end else begin
            if (load && (tx_idx < IDX_W'(STAT_BYTES)))
               tx_idx <= tx_idx + 1'b1;
            if (edg.fall) begin
               rx_sh <= {rx_sh[DATA_W-2:0], sdi};
               if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                  bit_cnt <= '0;
                  done    <= 1'b1;
                  rx_byte <= {rx_sh[DATA_W-2:0], sdi};
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
         end
      end
   end

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/sreg_resp.sv
module sreg_resp
   import sreg_pkg::*;
#(
   parameter int DATA_W                = 8,
   parameter int ADDR_W                = 7,
   parameter int STAT_BYTES            = 2,
   parameter logic [ADDR_W-1:0] DUMMY  = 7'h3F,
   localparam int IDX_W                = idx_width(STAT_BYTES),
   localparam int STAT_W               = STAT_BYTES * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              load,
   input  logic              shift,
   input  logic [IDX_W-1:0]  tx_idx,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic [STAT_W-1:0] stat,
   input  logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              tx_bit
);
   logic [DATA_W-1:0] pipe [STAT_BYTES];
   logic [DATA_W-1:0] tx_sh;
   logic [STAT_W-1:0] stat_q;
   logic              fetch;
   logic              cmd_ok;

   assign cmd_ok = rx_byte[DATA_W-1] && (rx_byte[ADDR_W-1:0] != DUMMY);
   assign tx_bit = tx_sh[DATA_W-1];

   // byte n of a status word, most significant byte first
   function automatic logic [DATA_W-1:0] stat_byte(input logic [STAT_W-1:0] w,
                                                   input logic [IDX_W-1:0] n);
      return w[(STAT_BYTES - 1 - int'(n)) * DATA_W +: DATA_W];
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAT_BYTES; i++) pipe[i] <= '0;
         tx_sh   <= '0;
         stat_q  <= '0;
         fetch   <= 1'b0;
         rd_addr <= '0;
      end else if (!sel) begin
         for (int i = 0; i < STAT_BYTES; i++) pipe[i] <= '0;
         tx_sh <= '0;
         fetch <= 1'b0;
      end else begin
         fetch <= done && cmd_ok;
         if (done) begin
            for (int i = 0; i < STAT_BYTES - 1; i++) pipe[i] <= pipe[i+1];
            pipe[STAT_BYTES-1] <= '0;
            if (cmd_ok) rd_addr <= rx_byte[ADDR_W-1:0];
         end
         if (fetch) pipe[STAT_BYTES-1] <= rd_data;
         if (load) begin
            if (tx_idx == '0) begin
               tx_sh  <= stat_byte(stat, '0);
               stat_q <= stat;
            end else if (tx_idx < IDX_W'(STAT_BYTES)) begin
               tx_sh <= stat_byte(stat_q, tx_idx);
            end else begin
               tx_sh <= pipe[0];
            end
         end else if (shift) begin
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
         end
      end
   end

   // R6
   addr_dummy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr != $past(rd_addr)) |-> (rd_addr != DUMMY));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(done) |-> $stable(rd_addr));

   // R3
   shift_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shift |=> (!sel || tx_sh[DATA_W-1] == $past(tx_sh[DATA_W-2])));
endmodule

// File: rtl/sreg_reader.sv
module sreg_reader
   import sreg_pkg::*;
#(
   parameter int DATA_W                    = 8,
   parameter int ADDR_W                    = 7,
   parameter int STAT_BYTES                = 2,
   parameter int SYNC_STAGES               = 2,
   parameter logic [ADDR_W-1:0] DUMMY_ADDR = 7'h3F,
   localparam int IDX_W                    = idx_width(STAT_BYTES),
   localparam int STAT_W                   = STAT_BYTES * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs,
   input  logic              spi_sck,
   input  logic              spi_sdi,
   output logic              spi_sdo,
   output logic              spi_sdo_oe,
   input  logic [STAT_W-1:0] status,
   output logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_data
);
   initial begin
      if (ADDR_W + 1 != DATA_W) $error("sreg_reader: command must be flag plus address");
      if (STAT_BYTES < 1)       $error("sreg_reader: STAT_BYTES must be at least 1");
      if (DATA_W < 2)           $error("sreg_reader: DATA_W must be at least 2");
   end

   logic              sel_s, sck_s, sdi_s;
   logic              load, shift, done, tx_bit;
   logic [DATA_W-1:0] rx_byte;
   logic [IDX_W-1:0]  tx_idx;

   sreg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs, spi_sck, spi_sdi}),
      .q     ({sel_s, sck_s, sdi_s})
   );

   sreg_frame #(.DATA_W(DATA_W), .STAT_BYTES(STAT_BYTES)) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_s),
      .sck     (sck_s),
      .sdi     (sdi_s),
      .load    (load),
      .shift   (shift),
      .done    (done),
      .rx_byte (rx_byte),
      .tx_idx  (tx_idx)
   );

   sreg_resp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STAT_BYTES(STAT_BYTES),
               .DUMMY(DUMMY_ADDR)) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel     (sel_s),
      .load    (load),
      .shift   (shift),
      .tx_idx  (tx_idx),
      .done    (done),
      .rx_byte (rx_byte),
      .stat    (status),
      .rd_data (reg_data),
      .rd_addr (reg_addr),
      .tx_bit  (tx_bit)
   );

   assign spi_sdo_oe = sel_s;
   assign spi_sdo    = sel_s & tx_bit;

   // R1
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !spi_sdo_oe |-> !spi_sdo);
endmodule

// File: tb/sreg_reader_tb.sv
module sreg_reader_tb;
   localparam int CLK_NS = 10;
   localparam int HALF   = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       spi_cs = 1'b0, spi_sck = 1'b0, spi_sdi = 1'b0;
   logic       spi_sdo, spi_sdo_oe;
   logic [15:0] status = '0;
   logic [6:0]  reg_addr;
   logic [7:0]  reg_data;

   int total = 0;
   int fails = 0;
   logic [6:0] exp_addr = '0;

   logic [7:0] expq[$];
   string      tagq[$];

   always #(CLK_NS/2) clk = ~clk;

   function automatic logic [7:0] mdl(input logic [6:0] a);
      return {a[3:0], a[6:4], ~a[0]} ^ 8'h5A;
   endfunction

   assign reg_data = mdl(reg_addr);

   sreg_reader u_dut (
      .clk(clk), .rst_n(rst_n), .spi_cs(spi_cs), .spi_sck(spi_sck),
      .spi_sdi(spi_sdi), .spi_sdo(spi_sdo), .spi_sdo_oe(spi_sdo_oe),
      .status(status), .reg_addr(reg_addr), .reg_data(reg_data)
   );

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: collect MISO bits at falling serial clock edges
   logic [7:0] mbyte = '0;
   int         mbits = 0;
   always @(negedge spi_sck or negedge spi_cs) begin
      if (!spi_cs) begin
         mbits = 0;
      end else begin
         mbyte = {mbyte[6:0], spi_sdo};
         mbits++;
         if (mbits == 8) begin
            mbits = 0;
            if (expq.size() == 0) begin
               chk(1'b0, "R5 unexpected byte", mbyte, 0);
            end else begin
               logic [7:0] e;
               string t;
               e = expq.pop_front();
               t = tagq.pop_front();
               chk(mbyte == e, t, mbyte, e);
            end
         end
      end
   end

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         @(negedge clk);
         spi_sdi = b[i];
         spi_sck = 1'b1;
         repeat (HALF) @(negedge clk);
         spi_sck = 1'b0;
         repeat (HALF - 1) @(negedge clk);
      end
   endtask

   function automatic logic [7:0] resp(input logic [7:0] c);
      return (c[7] && c[6:0] != 7'h3F) ? mdl(c[6:0]) : 8'h00;
   endfunction

   // full transaction of n command bytes, optional trailing partial bits
   task automatic xact(input logic [15:0] st, input logic [7:0] c [8],
                       input int n, input int tail);
      status = st;
      for (int j = 0; j < n; j++) begin
         if (j == 0)      begin expq.push_back(st[15:8]); tagq.push_back("R2 R3 status high"); end
         else if (j == 1) begin expq.push_back(st[7:0]);  tagq.push_back("R2 R8 status low"); end
         else begin
            expq.push_back(resp(c[j-2]));
            tagq.push_back((c[j-2][7] && c[j-2][6:0] != 7'h3F) ? "R5 data" : "R6 R7 zero");
         end
         if (c[j][7] && c[j][6:0] != 7'h3F) exp_addr = c[j][6:0];
      end
      @(negedge clk);
      spi_cs = 1'b1;
      repeat (HALF) @(negedge clk);
      for (int j = 0; j < n; j++) send_bits(c[j], 8);
      if (tail > 0) send_bits(8'hFF, tail);
      repeat (HALF) @(negedge clk);
      spi_cs = 1'b0;
      repeat (4 * HALF) @(negedge clk);
      chk(spi_sdo_oe == 1'b0 && spi_sdo == 1'b0, "R1 idle release",
          {spi_sdo_oe, spi_sdo}, 0);
      chk(reg_addr == exp_addr, "R4 R6 R7 address", reg_addr, exp_addr);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      // R9
      chk(reg_addr == 7'h00, "R9 reset address", reg_addr, 0);
      chk(spi_sdo_oe == 1'b0, "R9 reset enable", spi_sdo_oe, 0);
      chk(spi_sdo == 1'b0, "R9 reset data", spi_sdo, 0);

      xact(16'hA5C3, '{8'h85, 8'h9A, 8'hBF, 8'hBF, 0, 0, 0, 0}, 4, 0);
      // R7 write flag clear
      xact(16'h1234, '{8'h20, 8'hBF, 8'hBF, 0, 0, 0, 0, 0}, 3, 0);
      // R6 dummy address
      xact(16'h0FF0, '{8'hBF, 8'hFF, 8'hBF, 8'hBF, 0, 0, 0, 0}, 4, 0);
      xact(16'h8001, '{8'hBF, 8'hBF, 8'hBF, 0, 0, 0, 0, 0}, 3, 0);
      // R5 long stream
      xact(16'h6D2E, '{8'h80, 8'h81, 8'hFE, 8'hC0, 8'hBF, 8'hBF, 0, 0}, 6, 0);
      // R8 partial byte then restart
      xact(16'hBEEF, '{8'h90, 0, 0, 0, 0, 0, 0, 0}, 1, 4);
      xact(16'h5A96, '{8'h83, 8'hBF, 8'hBF, 0, 0, 0, 0, 0}, 3, 0);
      xact(16'hC001, '{8'hBF, 8'hBF, 0, 0, 0, 0, 0, 0}, 2, 5);

      chk(expq.size() == 0, "R5 all responses seen", expq.size(), 0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule